// File: doc/BRIEF.md
# FPGA byte-stream configuration loader

This block configures a slave FPGA through its byte-wide configuration port. Once reset is released it resets the target by holding the active-low program pin low for a set number of clocks. It then releases the pin and waits for the target's active-low init pin to read high. It writes a fixed eight-byte header. After that it takes bitstream bytes from an on-chip valid/ready stream and sends them in framed records. Each record opens with a sync code, carries a fixed number of payload bytes, closes with a check code and ends with trailer fill cycles.

A new record begins only when three conditions all hold: init is high, done is low, and the stream has not yet delivered its last-flagged byte. When any of them fails, the loader writes four startup fill bytes and stops. At that point it samples the target's done pin, which decides between a success flag and an error flag. If the payload runs out partway through a record, the empty payload slots are filled with 0xFF. If init never rises within a bounded wait, the loader flags an error without writing anything.

Every byte goes out as a write strobe held for a parameterised number of clocks, with the data bus steady for the whole strobe. The strobe then drops for at least one clock before the next byte. A new load requires a new reset.

Top module: `fpga_cfg_loader`

## Requirements
- R1: From reset, `busy` is 1 and `cfg_prog_n`, `cfg_wr`, `done_ok`, `error` and `s_ready` are 0. `cfg_prog_n` stays low through the first PROG_LOW_CYC rising edges after reset release, then goes high and never falls again until the next reset.
- R2: No byte is written while `cfg_init_n` has not yet been seen high. If `cfg_init_n` reads low on INIT_TIMEOUT consecutive edges after program release, the loader sets `error`, clears `busy` and writes no byte at all. `busy` falls exactly INIT_TIMEOUT clocks after `cfg_prog_n` rises.
- R3: The first eight bytes written are 0xFF, 0xFF, 0xFF, 0x4F, 0x80, 0xAF, 0x9B, 0x4B, in that order.
- R4: Each write holds `cfg_wr` high for exactly STROBE_CYC clocks, with `cfg_data` constant while it is high. `cfg_wr` is low for at least one clock between writes.
- R5: A record is 0x4F, then PAY_PER_FRAME payload bytes in stream order, then 0x4B, 0xFF, 0x4B, 0xFF, 0xFF, 0xFF.
- R6: If the byte flagged `s_last` is accepted before the payload slots of a record are full, each remaining slot is written as 0xFF. Once that byte is accepted, `s_ready` stays 0.
- R7: After the header and after each record, another record starts only if `cfg_init_n` is 1, `cfg_done` is 0 and the last-flagged byte has not been accepted. Otherwise the startup bytes follow at once.
- R8: After the last record, or after the exit that R7 describes, exactly four 0xFF bytes are written and nothing more.
- R9: When the startup bytes are done, `busy` falls. In the same step `done_ok` takes the value of `cfg_done` and `error` takes its inverse. The two flags are never both 1, and they hold until reset.
- R10: `s_ready` is never 1 while `cfg_wr` is 1, so a stream byte is only taken in the idle clock that starts its own strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset; its release starts a load |
| s_data | input | 8 | Bitstream byte |
| s_valid | input | 1 | Stream byte present |
| s_last | input | 1 | Marks the final bitstream byte |
| s_ready | output | 1 | Loader takes the byte on this edge |
| cfg_init_n | input | 1 | Target init pin, active low |
| cfg_done | input | 1 | Target done pin |
| cfg_prog_n | output | 1 | Target program pin, active low |
| cfg_wr | output | 1 | Configuration write strobe |
| cfg_data | output | 8 | Configuration data bus |
| busy | output | 1 | Load in progress |
| done_ok | output | 1 | Load finished with done high |
| error | output | 1 | Load finished with done low, or init timed out |

## Verification
Two events can land in the same clock: the closing trailer strobe of a record, and a change on the target pins that decides whether another record follows. The bench provokes this by dropping init, or raising done, while the last trailer byte of a record is still on the bus. Payload bytes are still pending in the stream at that moment. A scoreboard holds the exact expected byte sequence: header, the records already sent, then only the four startup bytes. Any extra record byte, or any missing startup byte, shows up as a mismatch, and the final flag pair must match the done pin.

// File: rtl/cfg_ldr_pkg.sv
package cfg_ldr_pkg;

   typedef enum logic [2:0] {
      ST_PROG,
      ST_WINIT,
      ST_HEAD,
      ST_FCHK,
      ST_FRAME,
      ST_START,
      ST_FIN
   } ldr_state_t;

   localparam int unsigned HEAD_LEN       = 8;
   localparam int unsigned START_LEN      = 4;
   localparam int unsigned FRAME_OVERHEAD = 7;

   localparam logic [7:0] B_FILL  = 8'hFF;
   localparam logic [7:0] B_SYNC  = 8'h4F;
   localparam logic [7:0] B_CHECK = 8'h4B;

   // Header bytes, in write order.
   function automatic logic [7:0] head_byte(input logic [2:0] i);
      logic [7:0] b;
      case (i)
         3'd3:    b = B_SYNC;
         3'd4:    b = 8'h80;
         3'd5:    b = 8'hAF;
         3'd6:    b = 8'h9B;
         3'd7:    b = B_CHECK;
         default: b = B_FILL;
      endcase
      return b;
   endfunction

endpackage

// File: rtl/cfg_ldr_timer.sv
module cfg_ldr_timer #(
   parameter int unsigned W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   output logic [W-1:0] cnt
);

   if (W < 1) begin : g_bad_w
      $error("cfg_ldr_timer: W must be at least 1");
   end

   // Saturating up-counter.
   always_ff @(posedge clk) begin
      if (!rst_n)          cnt <= '0;
      else if (clr)        cnt <= '0;
      else if (cnt != '1)  cnt <= cnt + W'(1);
   end

endmodule

// File: rtl/cfg_ldr_strobe.sv
module cfg_ldr_strobe #(
   parameter int unsigned STROBE_CYC = 4
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       go,
   input  logic [7:0] go_data,
   output logic       wr,
   output logic [7:0] data,
   output logic       last
);

   if (STROBE_CYC < 1) begin : g_bad_len
      $error("cfg_ldr_strobe: STROBE_CYC must be at least 1");
   end

   always_ff @(posedge clk) begin
      if (!rst_n)  data <= '0;
      else if (go) data <= go_data;
   end

   if (STROBE_CYC == 1) begin : g_single
      always_ff @(posedge clk) begin
         if (!rst_n) wr <= 1'b0;
         else        wr <= go;
      end
      assign last = wr;
   end else begin : g_count
      localparam int unsigned CW = $clog2(STROBE_CYC);
      logic [CW-1:0] cnt;
      assign last = wr && (cnt == CW'(STROBE_CYC - 1));
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            wr  <= 1'b0;
            cnt <= '0;
         end else if (go) begin
            wr  <= 1'b1;
            cnt <= '0;
         end else if (wr) begin
            if (last) wr  <= 1'b0;
            else      cnt <= cnt + CW'(1);
         end
      end
   end

   // R4: data bus steady while the strobe is held
   assert_data_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && $past(wr)) |-> $stable(data));

   // R4: a new byte is only launched from an idle strobe
   assert_go_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
      go |-> !wr);

endmodule

// File: rtl/fpga_cfg_loader.sv
module fpga_cfg_loader
   import cfg_ldr_pkg::*;
#(
   parameter int unsigned PROG_LOW_CYC  = 500,
   parameter int unsigned INIT_TIMEOUT  = 1000000,
   parameter int unsigned STROBE_CYC    = 4,
   parameter int unsigned PAY_PER_FRAME = 21
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [7:0] s_data,
   input  logic       s_valid,
   input  logic       s_last,
   output logic       s_ready,
   input  logic       cfg_init_n,
   input  logic       cfg_done,
   output logic       cfg_prog_n,
   output logic       cfg_wr,
   output logic [7:0] cfg_data,
   output logic       busy,
   output logic       done_ok,
   output logic       error
);

   localparam int unsigned TMAX      = (PROG_LOW_CYC > INIT_TIMEOUT) ? PROG_LOW_CYC : INIT_TIMEOUT;
   localparam int unsigned TW        = $clog2(TMAX + 1);
   localparam int unsigned FRAME_LEN = PAY_PER_FRAME + FRAME_OVERHEAD;
   localparam int unsigned IW        = $clog2(FRAME_LEN);

   localparam logic [IW-1:0] IDX_PAY_LO = IW'(1);
   localparam logic [IW-1:0] IDX_PAY_HI = IW'(PAY_PER_FRAME);
   localparam logic [IW-1:0] IDX_CHK_A  = IW'(PAY_PER_FRAME + 1);
   localparam logic [IW-1:0] IDX_CHK_B  = IW'(PAY_PER_FRAME + 3);
   localparam logic [IW-1:0] IDX_F_END  = IW'(FRAME_LEN - 1);
   localparam logic [IW-1:0] IDX_H_END  = IW'(HEAD_LEN - 1);
   localparam logic [IW-1:0] IDX_S_END  = IW'(START_LEN - 1);
   localparam logic [TW-1:0] T_PROG     = TW'(PROG_LOW_CYC - 1);
   localparam logic [TW-1:0] T_INIT     = TW'(INIT_TIMEOUT - 1);

   if (PROG_LOW_CYC < 1 || INIT_TIMEOUT < 1) begin : g_bad_time
      $error("fpga_cfg_loader: PROG_LOW_CYC and INIT_TIMEOUT must be at least 1");
   end
   if (PAY_PER_FRAME < 1) begin : g_bad_pay
      $error("fpga_cfg_loader: PAY_PER_FRAME must be at least 1");
   end
   if (STROBE_CYC < 1) begin : g_bad_strobe
      $error("fpga_cfg_loader: STROBE_CYC must be at least 1");
   end

   ldr_state_t    st;
   logic [IW-1:0] idx;
   logic [TW-1:0] tcnt;
   logic          tclr;
   logic          prog_n_q, busy_q, ok_q, err_q, last_seen;
   logic          wr, wr_last, go, in_pay, emit;
   logic [7:0]    go_data, fixed_byte;

   // ---------------- shared wait timer ----------------
   assign tclr = (st == ST_PROG) && (tcnt == T_PROG);

   cfg_ldr_timer #(.W(TW)) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (tclr),
      .cnt   (tcnt)
   );

   // ---------------- byte selection ----------------
   always_comb begin
      in_pay = (st == ST_FRAME) && (idx >= IDX_PAY_LO) && (idx <= IDX_PAY_HI);
      emit   = (st == ST_HEAD) || (st == ST_FRAME) || (st == ST_START);

      if (idx == '0)                              fixed_byte = B_SYNC;
      else if (idx == IDX_CHK_A || idx == IDX_CHK_B) fixed_byte = B_CHECK;
      else                                        fixed_byte = B_FILL;

      case (st)
         ST_HEAD:  go_data = head_byte(idx[2:0]);
         ST_FRAME: go_data = in_pay ? (last_seen ? B_FILL : s_data) : fixed_byte;
         default:  go_data = B_FILL;
      endcase

      s_ready = in_pay && !last_seen && !wr;
      go      = emit && !wr && (!in_pay || last_seen || s_valid);
   end

   cfg_ldr_strobe #(.STROBE_CYC(STROBE_CYC)) u_strobe (
      .clk     (clk),
      .rst_n   (rst_n),
      .go      (go),
      .go_data (go_data),
      .wr      (wr),
      .data    (cfg_data),
      .last    (wr_last)
   );

   // ---------------- sequencer ----------------
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st        <= ST_PROG;
         idx       <= '0;
         prog_n_q  <= 1'b0;
         busy_q    <= 1'b1;
         ok_q      <= 1'b0;
         err_q     <= 1'b0;
         last_seen <= 1'b0;
      end else begin
         if (s_ready && s_valid && s_last) last_seen <= 1'b1;
         case (st)
            ST_PROG: begin
               if (tcnt == T_PROG) begin
                  st       <= ST_WINIT;
                  prog_n_q <= 1'b1;
               end
            end
            ST_WINIT: begin
               if (cfg_init_n) begin
                  st  <= ST_HEAD;
                  idx <= '0;
               end else if (tcnt == T_INIT) begin
                  st     <= ST_FIN;
                  busy_q <= 1'b0;
                  err_q  <= 1'b1;
               end
            end
            ST_HEAD: begin
               if (wr_last) begin
                  if (idx == IDX_H_END) begin
                     st  <= ST_FCHK;
                     idx <= '0;
                  end else begin
                     idx <= idx + IW'(1);
                  end
               end
            end
            ST_FCHK: begin
               idx <= '0;
               if (cfg_init_n && !cfg_done && !last_seen) st <= ST_FRAME;
               else                                       st <= ST_START;
            end
            ST_FRAME: begin
               if (wr_last) begin
                  if (idx == IDX_F_END) begin
                     st  <= ST_FCHK;
                     idx <= '0;
                  end else begin
                     idx <= idx + IW'(1);
                  end
               end
            end
            ST_START: begin
               if (wr_last) begin
                  if (idx == IDX_S_END) begin
                     st     <= ST_FIN;
                     busy_q <= 1'b0;
                     ok_q   <= cfg_done;
                     err_q  <= !cfg_done;
                  end else begin
                     idx <= idx + IW'(1);
                  end
               end
            end
            default: ;
         endcase
      end
   end

   assign cfg_prog_n = prog_n_q;
   assign cfg_wr     = wr;
   assign busy       = busy_q;
   assign done_ok    = ok_q;
   assign error      = err_q;

   // ---------------- assertions ----------------
   // R1: no write strobe while the target is held in program
   assert_no_write_in_prog_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_prog_n |-> !cfg_wr);

   // R1: program line never drops again once released
   assert_prog_stays_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !$fell(cfg_prog_n));

   // R10: stream bytes only taken between strobes
   assert_accept_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
      s_ready |-> !cfg_wr);

   // R9: completion always leaves a verdict
   assert_end_verdict_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> (done_ok || error));

   // R9: verdict flags are exclusive
   assert_flags_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !(done_ok && error));

   // R6: nothing accepted after the last-flagged byte
   assert_no_accept_after_last_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (s_ready && s_valid && s_last) |=> !s_ready);

endmodule

// File: tb/fpga_cfg_loader_tb.sv
module fpga_cfg_loader_tb;

   localparam int CLK_PERIOD = 10;
   localparam int PLC  = 8;
   localparam int ITO  = 40;
   localparam int SC   = 3;
   localparam int PPF  = 21;
   localparam int FLEN = PPF + 7;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] s_data = '0;
   logic       s_valid = 1'b0;
   logic       s_last = 1'b0;
   logic       s_ready;
   logic       cfg_init_n = 1'b0;
   logic       cfg_done = 1'b0;
   logic       cfg_prog_n, cfg_wr, busy, done_ok, error;
   logic [7:0] cfg_data;

   always #(CLK_PERIOD/2) clk = ~clk;

   fpga_cfg_loader #(
      .PROG_LOW_CYC  (PLC),
      .INIT_TIMEOUT  (ITO),
      .STROBE_CYC    (SC),
      .PAY_PER_FRAME (PPF)
   ) u_dut (
      .clk(clk), .rst_n(rst_n),
      .s_data(s_data), .s_valid(s_valid), .s_last(s_last), .s_ready(s_ready),
      .cfg_init_n(cfg_init_n), .cfg_done(cfg_done),
      .cfg_prog_n(cfg_prog_n), .cfg_wr(cfg_wr), .cfg_data(cfg_data),
      .busy(busy), .done_ok(done_ok), .error(error)
   );

   int total = 0;
   int bad   = 0;

   logic [7:0] exp_q[$];
   string      tag_q[$];

   int   wr_seen, pre_init, hold_err, len_err, r10_err, r6_err;
   bit   init_seen, last_sent, stop;
   bit   prev_wr;
   int   hi_len;
   logic [7:0] held;

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int expv);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, expv);
      end
   endtask

   function automatic logic [7:0] pat(input int i, input int seed);
      return 8'((i * 37) + (seed * 11) + 5);
   endfunction

   task automatic push(input logic [7:0] b, input string t);
      exp_q.push_back(b);
      tag_q.push_back(t);
   endtask

   // Expected write sequence from the requirements.
   task automatic build_expect(input int n, input int seed, input int frames);
      logic [7:0] hdr [8] = '{8'hFF, 8'hFF, 8'hFF, 8'h4F, 8'h80, 8'hAF, 8'h9B, 8'h4B};
      exp_q.delete();
      tag_q.delete();
      for (int i = 0; i < 8; i++) push(hdr[i], "R3");
      for (int f = 0; f < frames; f++) begin
         push(8'h4F, "R5");
         for (int k = 0; k < PPF; k++) begin
            int p = f * PPF + k;
            if (p < n) push(pat(p, seed), "R5");
            else       push(8'hFF, "R6");
         end
         push(8'h4B, "R5"); push(8'hFF, "R5"); push(8'h4B, "R5");
         push(8'hFF, "R5"); push(8'hFF, "R5"); push(8'hFF, "R5");
      end
      for (int s = 0; s < 4; s++) push(8'hFF, "R8");
   endtask

   // Scoreboard monitor: samples away from the active edge.
   always @(negedge clk) begin
      if (!rst_n) begin
         prev_wr = 1'b0;
         hi_len  = 0;
      end else begin
         if (cfg_wr && !prev_wr) begin
            wr_seen++;
            held   = cfg_data;
            hi_len = 1;
            if (!init_seen) pre_init++;
            if (exp_q.size() == 0) begin
               check(1'b0, "R8", "unexpected extra write", cfg_data, 0);
            end else begin
               logic [7:0] e;
               string      t;
               e = exp_q.pop_front();
               t = tag_q.pop_front();
               check(cfg_data == e, t, $sformatf("byte %0d", wr_seen), cfg_data, e);
            end
         end else if (cfg_wr) begin
            hi_len++;
            if (cfg_data != held) hold_err++;
         end else if (prev_wr) begin
            if (hi_len != SC) len_err++;
         end
         if (s_ready && cfg_wr) r10_err++;
         if (s_ready && last_sent) r6_err++;
         if (cfg_init_n) init_seen = 1'b1;
         prev_wr = cfg_wr;
      end
   end

   task automatic send_stream(input int n, input int seed, input int gap);
      for (int i = 0; i < n; i++) begin
         bit ok;
         if (stop) break;
         @(negedge clk);
         s_valid = 1'b1;
         s_data  = pat(i, seed);
         s_last  = (i == n - 1);
         forever begin
            ok = s_ready;
            @(posedge clk);
            if (ok || stop) break;
            @(negedge clk);
         end
         if (ok && i == n - 1) last_sent = 1'b1;
         @(negedge clk);
         s_valid = 1'b0;
         s_last  = 1'b0;
         for (int g = 0; g < gap; g++) @(negedge clk);
      end
      s_valid = 1'b0;
   endtask

   task automatic wait_idle(output int c);
      c = 0;
      while (busy) begin
         @(negedge clk);
         c++;
      end
   endtask

   task automatic do_reset();
      int low;
      @(negedge clk);
      rst_n      = 1'b0;
      cfg_init_n = 1'b0;
      cfg_done   = 1'b0;
      s_valid    = 1'b0;
      s_last     = 1'b0;
      wr_seen = 0; pre_init = 0; hold_err = 0; len_err = 0; r10_err = 0; r6_err = 0;
      init_seen = 1'b0; last_sent = 1'b0; stop = 1'b0;
      repeat (3) @(negedge clk);
      check(busy == 1'b1 && cfg_prog_n == 1'b0 && cfg_wr == 1'b0 &&
            done_ok == 1'b0 && error == 1'b0 && s_ready == 1'b0,
            "R1", "reset state {busy,prog_n,wr,ok,err,ready}",
            {busy, cfg_prog_n, cfg_wr, done_ok, error, s_ready}, 6'b100000);
      rst_n = 1'b1;
      // R1: low through PLC edges -> PLC-1 low samples at the following negedges
      low = 0;
      forever begin
         @(negedge clk);
         if (cfg_prog_n) break;
         low++;
         if (low > PLC + 4) break;
      end
      check(low == PLC - 1, "R1", "program low samples", low, PLC - 1);
   endtask

   // mode: 0 none, 1 drop init at trigger, 2 raise done at trigger
   task automatic run_case(input int n, input int seed, input int gap,
                           input int init_delay, input bit hold_init,
                           input int trig, input int mode, input int frames,
                           input bit exp_ok, input bit exp_err);
      int c;
      do_reset();
      if (hold_init) begin
         exp_q.delete();
         tag_q.delete();
      end else begin
         build_expect(n, seed, frames);
      end
      for (int d = 0; d < init_delay; d++) @(negedge clk);
      if (!hold_init) cfg_init_n = 1'b1;
      c = 0;
      fork
         send_stream(hold_init ? 0 : n, seed, gap);
         begin
            if (mode != 0) begin
               wait (wr_seen >= trig);
               if (mode == 1) cfg_init_n = 1'b0;
               else           cfg_done   = 1'b1;
            end
            wait_idle(c);
            stop = 1'b1;
         end
      join
      repeat (3) @(negedge clk);
      if (hold_init) begin
         check(c == ITO, "R2", "clocks from program release to timeout", c, ITO);
         check(wr_seen == 0, "R2", "writes during init timeout", wr_seen, 0);
      end
      check(pre_init == 0, "R2", "writes before init high", pre_init, 0);
      check(exp_q.size() == 0, "R8", "expected writes not seen", exp_q.size(), 0);
      check(hold_err == 0, "R4", "data changes during strobe", hold_err, 0);
      check(len_err == 0, "R4", "strobes of wrong length", len_err, 0);
      check(r10_err == 0, "R10", "ready while strobing", r10_err, 0);
      check(r6_err == 0, "R6", "ready after last byte", r6_err, 0);
      check(busy == 1'b0, "R9", "busy at end", busy, 0);
      check(done_ok == exp_ok && error == exp_err,
            mode == 0 ? "R9" : "R7", "verdict {done_ok,error}",
            {done_ok, error}, {exp_ok, exp_err});
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      bad++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      // R5/R7/R9: two full records, done rises during the closing trailer strobe
      run_case(42, 1, 0, 3, 1'b0, 8 + 2 * FLEN, 2, 2, 1'b1, 1'b0);
      // R6: payload ends mid-record, gappy stream, slots padded
      run_case(25, 2, 1, 2, 1'b0, 8 + 2 * FLEN, 2, 2, 1'b1, 1'b0);
      // R2: init never rises
      run_case(0, 3, 0, 0, 1'b1, 0, 0, 0, 1'b0, 1'b1);
      // R7: init falls on the last trailer of record 1, payload still pending
      run_case(63, 4, 0, 1, 1'b0, 8 + FLEN, 1, 1, 1'b0, 1'b1);
      // R7: done rises on the last trailer of record 1, payload still pending
      run_case(63, 5, 0, 1, 1'b0, 8 + FLEN, 2, 1, 1'b1, 1'b0);
      // R2/R6: single-byte payload, init delayed well past program release
      run_case(1, 6, 2, 15, 1'b0, 8 + FLEN, 2, 1, 1'b1, 1'b0);
      // R9: payload fills exactly one record, done stays low
      run_case(21, 7, 0, 2, 1'b0, 0, 0, 1, 1'b0, 1'b1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule